// File: doc/BRIEF.md
# Flash Double-Word Program Sequencer with Row Mode

This block sits between a 32-bit write path and the program port of an embedded flash array. It pairs successive 32-bit writes into one 64-bit double-word and adds eight SECDED check bits. As soon as a pair is complete, it starts programming without further software action. Software sees progress through a busy flag, a sticky end-of-operation flag and two sticky error flags. Each flag is cleared by writing a one to its own bit.

Two modes are selected by level inputs. In standard mode one double-word is programmed per operation. To write a lone word, software pads the pair with the erased pattern 0xFFFFFFFF. In row mode a whole row of `ROW_DWORDS` double-words is streamed into the array's load path. The high-voltage phase then runs once for the whole row. Row mode needs a prior mass erase and a main-memory target.

Reads are treated differently in the two modes. During standard programming, every read is held off. During a row, the CPU that owns the row operation gets a bus error, and reads from any other requester are held off.

Top module: `flash_prog_seq`

## Requirements
- R1: With the standard mode bit set and the row bit clear, the first word write neither loads nor starts the array. The second word write raises `arr_load` for one cycle and raises `bsy` and `arr_go` on the next clock edge.
- R2: A standard load carries `arr_wdata[63:0]` = {second word, first word}. `arr_addr` is the second write's word address with bit 0 dropped. The load data stays stable while `arr_go` is high.
- R3: `arr_wdata[71:64]` holds SECDED check bits over these codeword positions:
  - check bit i (i = 0..6) sits at position 2^i;
  - data bits 0..63 fill the remaining positions 3, 5, 6, 7, 9, ... in ascending order;
  - bit 71 makes the parity of all 72 bits even.
- R4: On the edge where `arr_done` is seen while `arr_go` is high, `bsy` drops and `eop` rises. `eop` then holds until `flag_clr[0]` is written.
- R5: In row mode, a row is accepted under these conditions:
  - the row bit is set and the standard bit is clear;
  - `mass_erased` and `wr_main` are both high;
  - the first word address has its low log2(ROW_DWORDS)+1 bits at zero.
  The row takes 2*ROW_DWORDS consecutive word writes. Every odd word loads one double-word, giving ROW_DWORDS loads at ascending addresses. `bsy` and `arr_row` are high from the first write. `arr_go` rises only after the last write.
- R6: A row-mode write with `mass_erased` low or `wr_main` low sets `seq_err`. No load happens and `bsy` stays low.
- R7: In row mode, a misaligned first address, or any later address that is not the previous one plus one, sets `aln_err`. The partial row is abandoned: `bsy` drops, no further load happens and `arr_go` never rises.
- R8: A write while both mode bits are set sets `seq_err` and is discarded. A pending first word survives this and pairs with the next valid write.
- R9: A write while `arr_go` is high sets `seq_err`. It changes neither the load data nor the number of loads.
- R10: While standard programming is busy, `rd_req` gives `rd_stall` for any requester and never `rd_buserr`.
- R11: While a row is active, a read with `rd_own` high gives `rd_buserr` and no stall. A read with `rd_own` low gives `rd_stall` and no bus error.
- R12: After reset `bsy`, `eop`, `seq_err`, `aln_err`, `arr_load` and `arr_go` are low. The clear bits act one flag each: bit 0 clears `eop`, bit 1 clears `seq_err`, bit 2 clears `aln_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_en | input | 1 | Standard double-word mode bit |
| row_en | input | 1 | Row mode bit |
| mass_erased | input | 1 | Main array is in the mass-erased state |
| wr_valid | input | 1 | Word write strobe |
| wr_addr | input | WADDR_W | Word address of the write |
| wr_data | input | 32 | Write data word |
| wr_main | input | 1 | Write targets main memory |
| flag_clr | input | 3 | Write-one-to-clear: bit 0 eop, bit 1 seq_err, bit 2 aln_err |
| rd_req | input | 1 | Read request from some requester |
| rd_own | input | 1 | Read comes from the CPU that owns the operation |
| rd_stall | output | 1 | Hold off the read |
| rd_buserr | output | 1 | Answer the read with a bus error |
| bsy | output | 1 | Operation in progress |
| eop | output | 1 | Sticky end-of-operation flag |
| seq_err | output | 1 | Sticky sequence error flag |
| aln_err | output | 1 | Sticky address alignment error flag |
| arr_load | output | 1 | One-cycle load of a codeword into the array |
| arr_addr | output | WADDR_W-1 | Double-word address of the load |
| arr_wdata | output | 72 | Check bits and data of the load |
| arr_go | output | 1 | High-voltage program phase request |
| arr_row | output | 1 | The current operation is a row |
| arr_done | input | 1 | Array finished the program phase |

## Verification
The bench builds the block with its default values: rows of 32 double-words and a 12-bit word address. A full row then costs only 64 writes, so complete rows can be checked end to end. This includes the transition on the last double-word and an address break in the middle of a row. The array model's completion delay is drawn at random for each operation, which moves the end-of-operation edge against the read and write probes. Random data words exercise the check-bit positions across the whole double-word.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT2,
    S_PROG,
    S_DONE,
    S_ROWFILL,
    S_ROWPROG
  } seq_st_e;

  // SECDED over 64 data bits: check bit b at codeword position 2**b,
  // data in the remaining positions, top bit gives even overall parity.
  function automatic logic [7:0] secded8(input logic [63:0] d);
    logic [6:0] p;
    int k;
    p = '0;
    k = 0;
    for (int pos = 1; pos < 72; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        for (int b = 0; b < 7; b++) begin
          if (pos[b]) p[b] = p[b] ^ d[k[5:0]];
        end
        k++;
      end
    end
    return {^{d, p}, p};
  endfunction

endpackage

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import fps_pkg::*;
#(
  parameter int ROW_W   = 5,
  parameter int WADDR_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               std_en,
  input  logic               row_en,
  input  logic               mass_erased,
  input  logic               wr_valid,
  input  logic [WADDR_W-1:0] wr_addr,
  input  logic               wr_main,
  input  logic [2:0]         flag_clr,
  input  logic               arr_done,
  output logic               lo_we,
  output logic               ld,
  output logic               bsy,
  output logic               row_act,
  output logic               arr_go,
  output logic               eop,
  output logic               seq_err,
  output logic               aln_err
);

  localparam logic [WADDR_W-1:0] ONE = WADDR_W'(1);

  seq_st_e            st_q, st_n;
  logic [WADDR_W-1:0] exp_q, exp_n;
  logic               exp_we;
  logic               eop_set, seq_set, aln_set;
  logic               conflict, row_start, row_last, addr_hit;

  assign conflict  = std_en && row_en;
  assign row_start = (wr_addr[ROW_W:0] == '0);
  assign row_last  = &wr_addr[ROW_W:0];
  assign addr_hit  = (wr_addr == exp_q);

  always_comb begin
    st_n    = st_q;
    exp_n   = exp_q;
    exp_we  = 1'b0;
    lo_we   = 1'b0;
    ld      = 1'b0;
    eop_set = 1'b0;
    seq_set = 1'b0;
    aln_set = 1'b0;
    case (st_q)
      S_IDLE, S_DONE: begin
        st_n = S_IDLE;
        if (wr_valid) begin
          if (conflict) begin
            seq_set = 1'b1;
          end else if (std_en) begin
            lo_we = 1'b1;
            st_n  = S_WAIT2;
          end else if (row_en) begin
            if (!mass_erased || !wr_main) begin
              seq_set = 1'b1;
            end else if (!row_start) begin
              aln_set = 1'b1;
            end else begin
              lo_we  = 1'b1;
              exp_we = 1'b1;
              exp_n  = wr_addr + ONE;
              st_n   = S_ROWFILL;
            end
          end
        end
      end
      S_WAIT2: begin
        if (wr_valid) begin
          if (conflict) begin
            seq_set = 1'b1;
          end else begin
            ld   = 1'b1;
            st_n = S_PROG;
          end
        end
      end
      S_PROG, S_ROWPROG: begin
        if (wr_valid) seq_set = 1'b1;
        if (arr_done) begin
          eop_set = 1'b1;
          st_n    = S_DONE;
        end
      end
      S_ROWFILL: begin
        if (wr_valid) begin
          if (conflict) begin
            seq_set = 1'b1;
          end else if (!addr_hit) begin
            aln_set = 1'b1;
            st_n    = S_IDLE;
          end else begin
            exp_we = 1'b1;
            exp_n  = exp_q + ONE;
            if (wr_addr[0]) ld = 1'b1;
            else            lo_we = 1'b1;
            if (row_last) st_n = S_ROWPROG;
          end
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      exp_q <= '0;
    else if (exp_we) exp_q <= exp_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eop     <= 1'b0;
      seq_err <= 1'b0;
      aln_err <= 1'b0;
    end else begin
      eop     <= eop_set | (eop     & ~flag_clr[0]);
      seq_err <= seq_set | (seq_err & ~flag_clr[1]);
      aln_err <= aln_set | (aln_err & ~flag_clr[2]);
    end
  end

  assign arr_go  = (st_q == S_PROG) || (st_q == S_ROWPROG);
  assign row_act = (st_q == S_ROWFILL) || (st_q == S_ROWPROG);
  assign bsy     = arr_go || (st_q == S_ROWFILL);

  // R4: completion raises eop and releases busy
  p_done_sets_eop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_go && arr_done) |=> (eop && !bsy));

  // R4: eop is sticky without a clear
  p_eop_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eop && !flag_clr[0]) |=> eop);

  // R8: conflicting mode bits with a write flag a sequence error
  p_mode_conflict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && std_en && row_en) |=> seq_err);

  // R9: write during the program phase flags a sequence error
  p_busy_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_go && wr_valid) |=> seq_err);

endmodule

// File: rtl/fps_dpath.sv
module fps_dpath
  import fps_pkg::*;
#(
  parameter int WADDR_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lo_we,
  input  logic               ld,
  input  logic [WADDR_W-2:0] wr_dw_addr,
  input  logic [31:0]        wr_data,
  output logic               arr_load,
  output logic [WADDR_W-2:0] arr_addr,
  output logic [71:0]        arr_wdata
);

  logic [31:0] lo_q;
  logic [63:0] dw;

  assign dw = {wr_data, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_we) lo_q <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arr_load <= 1'b0;
    else        arr_load <= ld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_addr  <= '0;
      arr_wdata <= '0;
    end else if (ld) begin
      arr_addr  <= wr_dw_addr;
      arr_wdata <= {secded8(dw), dw};
    end
  end

  // R5: a load always needs a low word first, so loads never come back to back
  p_load_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    arr_load |=> !arr_load);

endmodule

// File: rtl/fps_rd_guard.sv
module fps_rd_guard (
  input  logic rd_req,
  input  logic rd_own,
  input  logic busy,
  input  logic row_act,
  output logic rd_stall,
  output logic rd_buserr
);

  logic own_row;

  assign own_row   = row_act & rd_own;
  assign rd_buserr = rd_req & own_row;
  assign rd_stall  = rd_req & busy & ~own_row;

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
  parameter int ROW_DWORDS = 32,
  parameter int WADDR_W    = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               std_en,
  input  logic               row_en,
  input  logic               mass_erased,
  input  logic               wr_valid,
  input  logic [WADDR_W-1:0] wr_addr,
  input  logic [31:0]        wr_data,
  input  logic               wr_main,
  input  logic [2:0]         flag_clr,
  input  logic               rd_req,
  input  logic               rd_own,
  output logic               rd_stall,
  output logic               rd_buserr,
  output logic               bsy,
  output logic               eop,
  output logic               seq_err,
  output logic               aln_err,
  output logic               arr_load,
  output logic [WADDR_W-2:0] arr_addr,
  output logic [71:0]        arr_wdata,
  output logic               arr_go,
  output logic               arr_row,
  input  logic               arr_done
);

  localparam int ROW_W = $clog2(ROW_DWORDS);

  logic lo_we, ld, row_act;

  fps_ctrl #(
    .ROW_W   (ROW_W),
    .WADDR_W (WADDR_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .std_en      (std_en),
    .row_en      (row_en),
    .mass_erased (mass_erased),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_main     (wr_main),
    .flag_clr    (flag_clr),
    .arr_done    (arr_done),
    .lo_we       (lo_we),
    .ld          (ld),
    .bsy         (bsy),
    .row_act     (row_act),
    .arr_go      (arr_go),
    .eop         (eop),
    .seq_err     (seq_err),
    .aln_err     (aln_err)
  );

  fps_dpath #(
    .WADDR_W (WADDR_W)
  ) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .lo_we      (lo_we),
    .ld         (ld),
    .wr_dw_addr (wr_addr[WADDR_W-1:1]),
    .wr_data    (wr_data),
    .arr_load   (arr_load),
    .arr_addr   (arr_addr),
    .arr_wdata  (arr_wdata)
  );

  fps_rd_guard u_rdg (
    .rd_req    (rd_req),
    .rd_own    (rd_own),
    .busy      (bsy),
    .row_act   (row_act),
    .rd_stall  (rd_stall),
    .rd_buserr (rd_buserr)
  );

  assign arr_row = row_act;

  // R2: the codeword under programming does not move
  p_prog_data_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_go && $past(arr_go)) |-> $stable(arr_wdata));

  // R10: standard programming never answers with a bus error
  p_std_no_buserr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy && !arr_row) |-> !rd_buserr);

  // R11: the owning CPU is never stalled during a row
  p_row_owner_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_own && arr_row) |-> !rd_stall);

endmodule

// File: tb/flash_prog_seq_bench.sv
module flash_prog_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_DWORDS = 32;
  localparam int WADDR_W    = 12;
  localparam int ROW_WORDS  = 2 * ROW_DWORDS;

  logic               clk;
  logic               rst_n;
  logic               std_en, row_en, mass_erased;
  logic               wr_valid;
  logic [WADDR_W-1:0] wr_addr;
  logic [31:0]        wr_data;
  logic               wr_main;
  logic [2:0]         flag_clr;
  logic               rd_req, rd_own;
  logic               rd_stall, rd_buserr;
  logic               bsy, eop, seq_err, aln_err;
  logic               arr_load;
  logic [WADDR_W-2:0] arr_addr;
  logic [71:0]        arr_wdata;
  logic               arr_go, arr_row, arr_done;

  int n_chk, n_bad;
  int dly, go_cnt;
  logic [71:0]        ld_data[$];
  logic [WADDR_W-2:0] ld_addr[$];

  flash_prog_seq #(
    .ROW_DWORDS (ROW_DWORDS),
    .WADDR_W    (WADDR_W)
  ) u_flash_prog_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .std_en      (std_en),
    .row_en      (row_en),
    .mass_erased (mass_erased),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_main     (wr_main),
    .flag_clr    (flag_clr),
    .rd_req      (rd_req),
    .rd_own      (rd_own),
    .rd_stall    (rd_stall),
    .rd_buserr   (rd_buserr),
    .bsy         (bsy),
    .eop         (eop),
    .seq_err     (seq_err),
    .aln_err     (aln_err),
    .arr_load    (arr_load),
    .arr_addr    (arr_addr),
    .arr_wdata   (arr_wdata),
    .arr_go      (arr_go),
    .arr_row     (arr_row),
    .arr_done    (arr_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // array model: logs loads, answers a program phase after dly cycles
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_done <= 1'b0;
      go_cnt   <= 0;
    end else begin
      if (arr_load) begin
        ld_data.push_back(arr_wdata);
        ld_addr.push_back(arr_addr);
      end
      if (arr_go && !arr_done) begin
        if (go_cnt >= dly) begin
          arr_done <= 1'b1;
          go_cnt   <= 0;
        end else begin
          go_cnt <= go_cnt + 1;
        end
      end else begin
        arr_done <= 1'b0;
      end
    end
  end

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // independent syndrome check of a 72-bit codeword
  function automatic logic ecc_ok(input logic [71:0] cw);
    logic [6:0] syn;
    logic       par;
    int         k;
    syn = '0;
    par = cw[71];
    k   = 0;
    for (int pos = 1; pos < 72; pos++) begin
      logic b;
      if ((pos & (pos - 1)) == 0) begin
        b = cw[64 + $clog2(pos)];
      end else begin
        b = cw[k];
        k++;
      end
      if (b) syn = syn ^ 7'(pos);
      par = par ^ b;
    end
    return (syn == '0) && (par == 1'b0);
  endfunction

  task automatic wr(input logic [WADDR_W-1:0] a, input logic [31:0] d);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic clr(input logic [2:0] m);
    flag_clr = m;
    @(negedge clk);
    flag_clr = 3'b000;
  endtask

  task automatic wait_idle();
    while (bsy) @(negedge clk);
  endtask

  task automatic std_op(input logic [WADDR_W-2:0] da, input logic [31:0] lo, input logic [31:0] hi);
    int n0;
    logic [71:0] cw;
    n0 = ld_data.size();
    wr({da, 1'b0}, lo);
    check("R1 first word no busy", bsy, 1'b0);
    check("R1 first word no load", arr_load, 1'b0);
    wr({da, 1'b1}, hi);
    check("R1 load pulse", arr_load, 1'b1);
    check("R1 busy after pair", bsy, 1'b1);
    check("R1 program phase", arr_go, 1'b1);
    rd_req = 1'b1;
    rd_own = 1'($urandom);
    #1;
    check("R10 stall during standard", rd_stall, 1'b1);
    check("R10 no bus error during standard", rd_buserr, 1'b0);
    rd_req = 1'b0;
    wait_idle();
    check("R4 eop at end", eop, 1'b1);
    @(negedge clk);
    check("R4 eop sticky", eop, 1'b1);
    check("R1 one load", 128'(ld_data.size()), 128'(n0 + 1));
    cw = ld_data[n0];
    check("R2 data order", cw[63:0], {hi, lo});
    check("R2 dword address", ld_addr[n0], da);
    check("R3 check bits", ecc_ok(cw), 1'b1);
    clr(3'b001);
    check("R4 eop cleared", eop, 1'b0);
  endtask

  task automatic row_op(input logic [WADDR_W-1:0] base);
    logic [31:0] rw[ROW_WORDS];
    int n0;
    n0 = ld_data.size();
    for (int i = 0; i < ROW_WORDS; i++) begin
      rw[i] = $urandom;
      wr(base + WADDR_W'(i), rw[i]);
      if (i == 0) begin
        check("R5 busy from first row write", bsy, 1'b1);
        check("R5 row flag", arr_row, 1'b1);
        rd_req = 1'b1;
        rd_own = 1'b1;
        #1;
        check("R11 owner bus error", rd_buserr, 1'b1);
        check("R11 owner not stalled", rd_stall, 1'b0);
        rd_own = 1'b0;
        #1;
        check("R11 other stalled", rd_stall, 1'b1);
        check("R11 other no bus error", rd_buserr, 1'b0);
        rd_req = 1'b0;
      end
      if (i == ROW_WORDS - 2) check("R5 no launch before last", arr_go, 1'b0);
    end
    check("R5 launch after last", arr_go, 1'b1);
    wait_idle();
    check("R4 eop after row", eop, 1'b1);
    check("R5 load count", 128'(ld_data.size()), 128'(n0 + ROW_DWORDS));
    for (int j = 0; j < ROW_DWORDS; j++) begin
      check("R5 row address", ld_addr[n0 + j], base[WADDR_W-1:1] + (WADDR_W-1)'(j));
      check("R5 row data", ld_data[n0 + j][63:0], {rw[2*j+1], rw[2*j]});
      check("R3 row check bits", ecc_ok(ld_data[n0 + j]), 1'b1);
    end
    clr(3'b001);
  endtask

  initial begin
    int n0;
    n_chk = 0; n_bad = 0; dly = 1;
    rst_n = 1'b0; std_en = 1'b0; row_en = 1'b0; mass_erased = 1'b0;
    wr_valid = 1'b0; wr_addr = '0; wr_data = '0; wr_main = 1'b1;
    flag_clr = 3'b000; rd_req = 1'b0; rd_own = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R12 reset bsy", bsy, 1'b0);
    check("R12 reset eop", eop, 1'b0);
    check("R12 reset seq_err", seq_err, 1'b0);
    check("R12 reset aln_err", aln_err, 1'b0);
    check("R12 reset load", arr_load, 1'b0);
    check("R12 reset go", arr_go, 1'b0);

    // standard mode: padded single word, then random pairs
    std_en = 1'b1;
    std_op(11'd5, 32'h1234_5678, 32'hFFFF_FFFF);
    for (int i = 0; i < 24; i++) begin
      dly = $urandom_range(0, 4);
      std_op(11'($urandom_range(0, 2047)), $urandom, $urandom);
    end

    // row mode, full row
    std_en = 1'b0; row_en = 1'b1; mass_erased = 1'b1; wr_main = 1'b1;
    dly = 3;
    row_op(12'd192);

    // R6: preconditions
    mass_erased = 1'b0;
    wr(12'd256, 32'hA5A5_0001);
    check("R6 no erase sets seq_err", seq_err, 1'b1);
    check("R6 no erase not busy", bsy, 1'b0);
    check("R6 no erase no load", arr_load, 1'b0);
    clr(3'b010);
    check("R12 seq_err cleared", seq_err, 1'b0);
    mass_erased = 1'b1; wr_main = 1'b0;
    wr(12'd256, 32'hA5A5_0002);
    check("R6 non-main sets seq_err", seq_err, 1'b1);
    check("R6 non-main not busy", bsy, 1'b0);
    clr(3'b010);
    wr_main = 1'b1;

    // R7: misaligned start, then break inside the row
    wr(12'd258, 32'h0BAD_0001);
    check("R7 misaligned start", aln_err, 1'b1);
    check("R7 misaligned not busy", bsy, 1'b0);
    clr(3'b100);
    n0 = ld_data.size();
    for (int i = 0; i < 6; i++) wr(12'd320 + 12'(i), $urandom);
    check("R7 busy in fill", bsy, 1'b1);
    wr(12'd327, 32'h0BAD_0002);
    check("R7 skip sets aln_err", aln_err, 1'b1);
    check("R7 fill abandoned", bsy, 1'b0);
    check("R7 row flag dropped", arr_row, 1'b0);
    repeat (3) @(negedge clk);
    check("R7 no program phase", arr_go, 1'b0);
    check("R7 loads before break", 128'(ld_data.size()), 128'(n0 + 3));
    clr(3'b100);
    row_op(12'd320);

    // R8: both mode bits
    std_en = 1'b1;
    wr(12'd10, 32'h1111_1111);
    check("R8 conflict sets seq_err", seq_err, 1'b1);
    check("R8 conflict not busy", bsy, 1'b0);
    clr(3'b010);
    row_en = 1'b0;
    n0 = ld_data.size();
    wr(12'd20, 32'hAAAA_0000);
    row_en = 1'b1;
    wr(12'd21, 32'hBBBB_0000);
    check("R8 second word conflict", seq_err, 1'b1);
    check("R8 conflict no load", arr_load, 1'b0);
    row_en = 1'b0;
    wr(12'd21, 32'hCCCC_0000);
    check("R8 pending word launches", bsy, 1'b1);
    wait_idle();
    check("R8 kept first word", ld_data[n0][63:0], {32'hCCCC_0000, 32'hAAAA_0000});
    clr(3'b011);

    // R9: write during the program phase
    dly = 8;
    n0 = ld_data.size();
    wr(12'd40, 32'h4040_4040);
    wr(12'd41, 32'h4141_4141);
    check("R9 busy", arr_go, 1'b1);
    wr(12'd60, 32'hDEAD_BEEF);
    check("R9 write while busy flags", seq_err, 1'b1);
    check("R9 data unchanged", arr_wdata[63:0], {32'h4141_4141, 32'h4040_4040});
    wait_idle();
    @(negedge clk);
    check("R9 no extra load", 128'(ld_data.size()), 128'(n0 + 1));
    check("R9 programmed data", ld_data[n0][63:0], {32'h4141_4141, 32'h4040_4040});

    // R12: per-bit clears with all three flags set
    std_en = 1'b0; row_en = 1'b1;
    wr(12'd2, 32'h0);
    check("R12 aln set", aln_err, 1'b1);
    clr(3'b010);
    check("R12 clear seq only", seq_err, 1'b0);
    check("R12 aln kept", aln_err, 1'b1);
    check("R12 eop kept", eop, 1'b1);
    clr(3'b100);
    check("R12 clear aln", aln_err, 1'b0);
    check("R12 eop still kept", eop, 1'b1);
    clr(3'b001);
    check("R12 clear eop", eop, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule